// File: doc/BRIEF.md
# Per-Line Palette Pixel Renderer

This block turns a packed framebuffer into a stream of 8-bit colour values, one per pixel clock. The framebuffer is a sequence of scanline records. Each record opens with a small table of 8-bit colours, followed by packed palette indices. Because that colour table is reloaded from memory on every line, the frame as a whole can use all 256 colours while any single line is limited to 16 or 4 of them.

Each line starts with a `line_start` pulse. During the horizontal blanking after it, the block reads the record's colour table into a line palette. It then prefetches pixel bytes into a small queue. While `active_en` is high it unpacks one index per clock, looks it up in the palette, and registers the result onto `pix_color`.

A `frame_start` pulse samples the colour mode and the frame's base address. Memory is read through a request/valid port that returns data in request order. Sync generation, the DAC and arbitration for the memory are handled outside the block.

Top module: `linepal_renderer`

## Requirements
- R1: With `mode_sel`=0 (16-colour mode), a record is 16 colour bytes followed by 160 index bytes. An index k selects the colour stored at record offset k. The whole colour table is loaded before any index byte enters the prefetch queue.
- R2: In 16-colour mode each index byte holds two 4-bit indices. The left pixel uses bits 7:4 and the right pixel uses bits 3:0.
- R3: With `mode_sel`=1 (4-colour mode), a record is 4 colour bytes followed by 80 index bytes. Each index byte holds four 2-bit indices. The leftmost pixel uses bits 7:6, then bits 5:4, 3:2 and 1:0.
- R4: Records are contiguous. Line k after a `frame_start` begins at base + k×176 in 16-colour mode, or base + k×84 in 4-colour mode.
- R5: Active pixel n of a line reads index byte (scroll + n / pixels-per-byte) mod bytes-per-line. `scroll` is sampled at `line_start` and must be below bytes-per-line. One scroll step is therefore 2 pixels in 16-colour mode and 4 pixels in 4-colour mode.
- R6: `mode_sel` and `base_addr` are sampled only at `frame_start`. Changing them mid-frame does not affect the lines of the current frame.
- R7: The colour of the n-th active cycle of a line appears on `pix_color` one clock after that cycle. After any cycle with `active_en` low, `pix_color` is 0.
- R8: After reset, `pix_color` is 0 and `mem_req` stays low until the first `line_start`.
- R9: A `line_start` abandons whatever the previous line had not shown. This includes queued bytes and responses still in flight. The new line is rendered correctly even when the previous active period was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse in blanking before the first line of a frame |
| line_start | input | 1 | One-cycle pulse at the start of each line's blanking |
| active_en | input | 1 | High during the active pixels of a line |
| mode_sel | input | 1 | 0 = 16 colours per line, 1 = 4 colours per line |
| base_addr | input | AW (20) | Byte address of the frame's first record |
| scroll | input | SCROLL_W (8) | Coarse horizontal scroll in index bytes |
| mem_req | output | 1 | Read request, one byte per asserted cycle |
| mem_addr | output | AW (20) | Byte address of the request |
| mem_valid | input | 1 | Read data valid, responses in request order |
| mem_data | input | 8 | Read data |
| pix_color | output | 8 | Output colour, 0 outside active video |

## Verification
The reference model is run against lines in both modes with scroll at 0, at a mid value, and at the last byte of the line. Together these show nibble or bit-pair ordering, the scroll step size, and wrap-around inside a record. Successive lines of one frame, and frames with different bases, show the record stride. A `mode_sel` and `base_addr` change issued mid-frame shows whether sampling happens only at frame start. Lines cut short at odd lengths, with memory latencies of 1 to 3 cycles, show that stale queued bytes and late responses never leak into the next line.

// File: rtl/lpr_pkg.sv
// Shared types for the per-line palette renderer.
package lpr_pkg;

    // Fetch sequencer phases within one scanline.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,   // no line started since reset
        S_DRAIN = 3'd1,   // discarding responses of the previous line
        S_HDR   = 3'd2,   // issuing colour-table reads
        S_DATA  = 3'd3,   // issuing index-byte reads
        S_DONE  = 3'd4    // all reads of this line issued
    } fetch_state_e;

endpackage

// File: rtl/lpr_fifo.sv
// Byte prefetch queue with show-ahead output.
// Assumes DEPTH is a power of two; flush has priority over push and pop.
module lpr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CNW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           push,
    input  logic [W-1:0]   din,
    input  logic           pop,
    output logic [W-1:0]   dout,
    output logic [CNW-1:0] count
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_q, rd_q;

    assign dout = store[rd_q];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
            count <= count + CNW'(push) - CNW'(pop);
        end
    end

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push && !flush) store[wr_q] <= din;
    end

    // R7: a pixel byte must be present whenever the unpacker takes one.
    a_r7_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> (count != '0));
    // R9: the request throttle never lets responses overfill the queue.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> (count != CNW'(DEPTH)));

endmodule

// File: rtl/lpr_palette.sv
// Line palette register file: one write port, one combinational read port.
// Assumes writes and reads of one line never overlap in time.
module lpr_palette #(
    parameter int ENTRIES = 16,
    parameter int CW      = 8,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [CW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [CW-1:0] rdata
);
    logic [CW-1:0] ent [ENTRIES];

    assign rdata = ent[ridx];

    // Load colour entries from the record header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
        end else if (we) begin
            ent[widx] <= wdata;
        end
    end

endmodule

// File: rtl/lpr_fetch.sv
// Fetch sequencer: walks scanline records, loads the colour table into the
// palette, then streams index bytes into the prefetch queue.
// Assumes the memory accepts a request every cycle and answers in order.
module lpr_fetch
    import lpr_pkg::*;
#(
    parameter int AW       = 20,
    parameter int ACTIVE_W = 320,
    parameter int DEPTH    = 4,
    parameter int OW       = $clog2(ACTIVE_W / 2),
    parameter int CNW      = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic           line_start,
    input  logic           mode_sel,
    input  logic [AW-1:0]  base_addr,
    input  logic [OW-1:0]  scroll,
    input  logic           mem_valid,
    input  logic [7:0]     mem_data,
    input  logic [CNW-1:0] fifo_count,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output logic           pal_we,
    output logic [3:0]     pal_widx,
    output logic           fifo_push,
    output logic           mode_o
);
    localparam int BPL16 = ACTIVE_W / 2;
    localparam int BPL4  = ACTIVE_W / 4;
    localparam int HDR16 = 16;
    localparam int HDR4  = 4;
    localparam int IFW   = $clog2(HDR16 + DEPTH + 1);

    fetch_state_e  state_q;
    logic          mode_q, mode_eff, rsp_ok, room;
    logic [AW-1:0] rec_q, next_q, rec_src, stride_eff;
    logic [OW-1:0] off_q;
    logic [OW:0]   data_iss_q, bpl, bpl_eff;
    logic [4:0]    hdr_iss_q, hdr_rcv_q, hdr_len;
    logic [IFW-1:0] infl_q;

    // Geometry of the current and the about-to-start line.
    always_comb begin
        hdr_len    = mode_q ? 5'(HDR4) : 5'(HDR16);
        bpl        = mode_q ? (OW+1)'(BPL4) : (OW+1)'(BPL16);
        mode_eff   = frame_start ? mode_sel : mode_q;
        rec_src    = frame_start ? base_addr : next_q;
        stride_eff = mode_eff ? AW'(HDR4 + BPL4) : AW'(HDR16 + BPL16);
        bpl_eff    = mode_eff ? (OW+1)'(BPL4) : (OW+1)'(BPL16);
        room       = ((IFW+1)'(fifo_count) + (IFW+1)'(infl_q)) < (IFW+1)'(DEPTH);
    end

    // Request issue and response routing.
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = rec_q + AW'(hdr_iss_q);
        if (!line_start) begin
            if (state_q == S_HDR) begin
                mem_req = hdr_iss_q < hdr_len;
            end else if (state_q == S_DATA) begin
                mem_req  = room && (data_iss_q < bpl);
                mem_addr = rec_q + AW'(hdr_len) + AW'(off_q);
            end
        end
        rsp_ok    = mem_valid && !line_start &&
                    (state_q == S_HDR || state_q == S_DATA || state_q == S_DONE);
        pal_we    = rsp_ok && (hdr_rcv_q < hdr_len);
        fifo_push = rsp_ok && !pal_we;
    end

    assign pal_widx = hdr_rcv_q[3:0];
    assign mode_o   = mode_q;

    // Sequencer, address walk and in-flight accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            mode_q     <= 1'b0;
            rec_q      <= '0;
            next_q     <= '0;
            off_q      <= '0;
            data_iss_q <= '0;
            hdr_iss_q  <= '0;
            hdr_rcv_q  <= '0;
            infl_q     <= '0;
        end else begin
            infl_q <= infl_q + IFW'(mem_req) - IFW'(mem_valid);
            if (frame_start) begin
                mode_q <= mode_sel;
                next_q <= base_addr;
            end
            if (line_start) begin
                mode_q     <= mode_eff;
                rec_q      <= rec_src;
                next_q     <= rec_src + stride_eff;
                off_q      <= scroll;
                hdr_iss_q  <= '0;
                hdr_rcv_q  <= '0;
                data_iss_q <= '0;
                state_q    <= S_DRAIN;
            end else begin
                if (pal_we) hdr_rcv_q <= hdr_rcv_q + 5'd1;
                case (state_q)
                    S_DRAIN: if (infl_q == '0) state_q <= S_HDR;
                    S_HDR: if (mem_req) begin
                        hdr_iss_q <= hdr_iss_q + 5'd1;
                        if (hdr_iss_q == hdr_len - 5'd1) state_q <= S_DATA;
                    end
                    S_DATA: if (mem_req) begin
                        off_q      <= ((OW+1)'(off_q) == bpl - 1'b1) ? '0 : off_q + 1'b1;
                        data_iss_q <= data_iss_q + 1'b1;
                        if (data_iss_q == bpl - 1'b1) state_q <= S_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: nothing is read before the first line begins.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !mem_req);
    // R1: the whole colour table is in place before any index byte is queued.
    a_r1_table_first: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (hdr_rcv_q == hdr_len));
    // R5: the scroll offset must lie inside the line's index bytes.
    a_r5_scroll_range: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> ((OW+1)'(scroll) < bpl_eff));
    // R9: stale responses are dropped while draining.
    a_r9_drain_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DRAIN) |-> !(pal_we || fifo_push));

endmodule

// File: rtl/linepal_renderer.sv
// Top of the per-line palette renderer: fetch sequencer, line palette,
// prefetch queue and the index unpacker driving the registered colour output.
// Assumes blanking after line_start is long enough to load the table and
// prime the queue before active_en rises.
module linepal_renderer
    import lpr_pkg::*;
#(
    parameter int AW         = 20,
    parameter int ACTIVE_W   = 320,
    parameter int FIFO_DEPTH = 4,
    parameter int SCROLL_W   = $clog2(ACTIVE_W / 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic                active_en,
    input  logic                mode_sel,
    input  logic [AW-1:0]       base_addr,
    input  logic [SCROLL_W-1:0] scroll,
    output logic                mem_req,
    output logic [AW-1:0]       mem_addr,
    input  logic                mem_valid,
    input  logic [7:0]          mem_data,
    output logic [7:0]          pix_color
);
    localparam int CNW = $clog2(FIFO_DEPTH + 1);

    logic           pal_we, fifo_push, fifo_pop, mode_q, need;
    logic [3:0]     pal_widx, idx;
    logic [7:0]     fifo_dout, pal_rdata, src, sh_q;
    logic [1:0]     left_q;
    logic [CNW-1:0] fifo_count;

    lpr_fetch #(.AW(AW), .ACTIVE_W(ACTIVE_W), .DEPTH(FIFO_DEPTH),
                .OW(SCROLL_W), .CNW(CNW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .mode_sel(mode_sel), .base_addr(base_addr),
        .scroll(scroll), .mem_valid(mem_valid), .mem_data(mem_data),
        .fifo_count(fifo_count), .mem_req(mem_req), .mem_addr(mem_addr),
        .pal_we(pal_we), .pal_widx(pal_widx), .fifo_push(fifo_push),
        .mode_o(mode_q));

    lpr_palette #(.ENTRIES(16), .CW(8)) u_pal (
        .clk(clk), .rst_n(rst_n), .we(pal_we), .widx(pal_widx),
        .wdata(mem_data), .ridx(idx), .rdata(pal_rdata));

    lpr_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .CNW(CNW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(line_start), .push(fifo_push),
        .din(mem_data), .pop(fifo_pop), .dout(fifo_dout), .count(fifo_count));

    // Pick the next index: fresh byte when the current one is used up.
    always_comb begin
        need     = active_en && (left_q == 2'd0);
        fifo_pop = need;
        src      = need ? fifo_dout : sh_q;
        idx      = mode_q ? {2'b00, src[7:6]} : src[7:4];
    end

    // Shift register holding the rest of the current index byte.
    always_ff @(posedge clk) begin
        if (!rst_n || line_start) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (active_en) begin
            sh_q   <= mode_q ? {src[5:0], 2'b00} : {src[3:0], 4'b0000};
            left_q <= need ? (mode_q ? 2'd3 : 2'd1) : left_q - 2'd1;
        end
    end

    // Registered colour output, black outside active video.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_color <= '0;
        else        pix_color <= active_en ? pal_rdata : 8'h00;
    end

    // R7: blank cycles produce colour 0 on the next clock.
    a_r7_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active_en |=> (pix_color == 8'h00));

endmodule

// File: tb/linepal_renderer_tb.sv
// Reference-model bench for linepal_renderer: the expected colour of every
// clock is computed from the record layout rules and compared each cycle.
module linepal_renderer_tb;
    localparam int CLK_NS = 10;
    localparam int AW     = 20;
    localparam int W      = 320;
    localparam int SCW    = $clog2(W / 2);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_start = 1'b0, line_start = 1'b0, active_en = 1'b0;
    logic           mode_sel = 1'b0;
    logic [AW-1:0]  base_addr = '0;
    logic [SCW-1:0] scroll = '0;
    logic           mem_req, mem_valid = 1'b0;
    logic [AW-1:0]  mem_addr;
    logic [7:0]     mem_data = '0;
    logic [7:0]     pix_color;

    int vectors = 0, fails = 0, mem_lat = 1;
    int m_mode = 0, m_next = 0, m_rec = 0, m_scroll = 0, m_n = 0;
    int q_addr[$], q_cd[$];
    string tag = "R7";

    always #(CLK_NS/2) clk = ~clk;

    linepal_renderer #(.AW(AW), .ACTIVE_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .active_en(active_en), .mode_sel(mode_sel),
        .base_addr(base_addr), .scroll(scroll), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
        .pix_color(pix_color));

    function automatic logic [7:0] memb(input int a);
        return 8'(a * 73 + (a >> 4) * 29 + 5);
    endfunction

    // In-order memory with a programmable latency.
    always @(negedge clk) begin
        mem_valid = 1'b0;
        foreach (q_cd[i]) q_cd[i]--;
        if (q_cd.size() > 0 && q_cd[0] <= 0) begin
            mem_valid = 1'b1;
            mem_data  = memb(q_addr[0]);
            void'(q_addr.pop_front());
            void'(q_cd.pop_front());
        end
        if (rst_n && mem_req) begin
            q_addr.push_back(int'(mem_addr));
            q_cd.push_back(mem_lat);
        end
    end

    // Expected colour of active pixel m_n (R1, R2, R3, R5).
    function automatic int expect_col();
        int ppb, bpl, hdr, b, pos, ix;
        ppb = m_mode ? 4 : 2;
        bpl = m_mode ? 80 : 160;
        hdr = m_mode ? 4 : 16;
        b   = memb(m_rec + hdr + ((m_scroll + m_n / ppb) % bpl));
        pos = m_n % ppb;
        ix  = m_mode ? ((b >> (6 - 2 * pos)) & 3) : ((b >> (4 - 4 * pos)) & 15);
        return memb(m_rec + ix);
    endfunction

    task automatic check(input logic [7:0] act, input int expv, input string t);
        vectors++;
        if (act !== 8'(expv)) begin
            fails++;
            $display("FAIL %s: pix_color=%0h expected %0h at %0t", t, act, expv, $time);
        end
    endtask

    task automatic step(input bit fs, input bit ls, input bit act);
        int expv;
        frame_start = fs; line_start = ls; active_en = act;
        if (fs) begin m_mode = mode_sel; m_next = int'(base_addr); end   // R6
        if (ls) begin
            m_rec = m_next; m_next += m_mode ? 84 : 176;                 // R4
            m_scroll = int'(scroll); m_n = 0;
        end
        expv = act ? expect_col() : 0;
        if (act) m_n++;
        @(posedge clk); @(negedge clk);
        check(pix_color, expv, act ? tag : (rst_n ? "R7" : "R8"));
    endtask

    task automatic do_line(input int sc, input int act_len, input string t);
        scroll = SCW'(sc);
        tag = t;
        step(0, 1, 0);
        repeat (40) step(0, 0, 0);
        repeat (act_len) step(0, 0, 1);
        repeat (8) step(0, 0, 0);
    endtask

    task automatic do_frame(input bit md, input int base, input int lat);
        mem_lat = lat;
        mode_sel = md;
        base_addr = AW'(base);
        step(1, 0, 0);
        repeat (3) step(0, 0, 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) step(0, 0, 0);                   // R8: output 0 under reset
        rst_n = 1'b1;
        repeat (4) begin
            step(0, 0, 0);
            vectors++;
            if (mem_req !== 1'b0) begin              // R8: no reads before a line
                fails++;
                $display("FAIL R8: mem_req=%0b expected 0", mem_req);
            end
        end
        // Frame A: 16-colour mode, latency 1.
        do_frame(1'b0, 0, 1);
        do_line(0, W, "R1");
        mode_sel = 1'b1; base_addr = AW'(5000);     // R6: ignored until next frame
        do_line(7, W, "R6");
        do_line(159, W, "R5");                       // scroll wraps within the line
        // Frame B: 4-colour mode, latency 3.
        do_frame(1'b1, 3000, 3);
        do_line(0, W, "R3");
        do_line(79, W, "R5");
        do_line(5, 100, "R9");                       // cut short
        do_line(2, W, "R9");
        do_line(40, W, "R4");
        // Frame C: 16-colour mode at an odd base, latency 2.
        do_frame(1'b0, 777, 2);
        do_line(0, W, "R4");
        do_line(11, 37, "R9");
        do_line(3, W, "R2");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule